// File: doc/BRIEF.md
# PCI Memory-Read Burst Initiator

This block is the read half of a PCI bus master. Given a start address and a byte count, it requests the bus. Once granted, it runs a memory-read transaction and drives FRAME#, C/BE[3:0]# and IRDY#. It leaves AD undriven for one turnaround clock after the address phase. After that it writes one dword into a local receive FIFO on every clock in which the target asserts TRDY#. The target side (DEVSEL#, TRDY#, STOP#) and the arbiter are outside the block. Parity and write transactions are not part of it.

The burst always uses linear ordering, so AD[1:0] is driven as 00 in the address phase. The burst stays open as long as the target keeps up, and ends cleanly on the first of these conditions:
- the byte count is about to run out;
- the FIFO is about to run out of room;
- the grant is withdrawn;
- bus mastering is disabled;
- the target asserts STOP#;
- a higher-priority write is pending while priority mode is on.

To end, the block deasserts FRAME# while IRDY# stays asserted for one last data phase. It releases IRDY# once that phase completes.

The controller has five states. IDLE goes to REQ on an accepted start. REQ goes to ADDR on grant, or back to IDLE if mastering is disabled. ADDR always goes to TURN. TURN always goes to DATA. DATA returns to IDLE when the final phase completes by TRDY# or STOP#. A flag called "final" is set when the block decides to end the burst. While the flag is set, FRAME# is deasserted in TURN and DATA.

Top module: `pci_rd_burst_master`

## Requirements
- R1: After reset, req_n, frame_n and irdy_n are 1, while ctl_oe, ad_oe, fifo_wr and busy are 0.
- R2: A start pulse is ignored when byte_cnt holds no whole dword (bits above bit 1 are all zero) or while the block is busy. The two low bits of byte_cnt are always dropped.
- R3: req_n goes low in the cycle after an accepted start. The address phase starts in the cycle after gnt_n is sampled low, provided master_en is 1, no blocking priority write is pending and fifo_free is nonzero. In the address phase: frame_n is 0, irdy_n is 1, ad_oe is 1, ad_out is start_addr with bits 1:0 forced to 00 (linear order), and cbe_n is 4'b0110 (memory read).
- R4: The cycle after the address phase is a turnaround. In it, ad_oe is 0, irdy_n is 0, cbe_n is 4'b0000, and no data is accepted even if trdy_n is low.
- R5: From the cycle after the turnaround, each cycle with irdy_n and trdy_n both low raises fifo_wr with fifo_wdata equal to ad_in. rem_bytes drops by 4 at the following edge. No wait state is added between transfers.
- R6: When a completed phase leaves exactly one dword of byte count, frame_n is 1 from the next cycle. A one-dword read has frame_n at 1 already in the turnaround.
- R7: The final phase is announced while at least one FIFO entry is still free. fifo_wr is never high while fifo_free is 0.
- R8: If gnt_n is sampled high while frame_n and irdy_n are both low, frame_n is 1 in the next cycle.
- R9: With prio_mode at 1, a high prio_pend during the burst ends it like R8, and during REQ it holds off the address phase. With prio_mode at 0, prio_pend has no effect.
- R10: If master_en is sampled low during the burst, the burst ends like R8. If it is low in REQ, the block returns to IDLE without an address phase.
- R11: If stop_n is sampled low while frame_n is low, frame_n is 1 next cycle. If stop_n is low while frame_n is 1 and irdy_n is 0, the transaction ends.
- R12: frame_n is never 1 while ctl_oe is 1 unless irdy_n is 0. When the final phase completes, frame_n and irdy_n are 1 and ctl_oe is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a read burst (one-cycle pulse) |
| start_addr | input | AW | Byte address of the first dword |
| byte_cnt | input | CNT_W | Number of bytes to read |
| master_en | input | 1 | Bus mastering allowed |
| prio_mode | input | 1 | Let a pending priority write end the burst |
| prio_pend | input | 1 | Higher-priority write is waiting |
| req_n | output | 1 | Bus request, active low |
| gnt_n | input | 1 | Bus grant, active low |
| frame_n | output | 1 | FRAME#, active low |
| irdy_n | output | 1 | IRDY#, active low |
| cbe_n | output | 4 | Command / byte enables, active low |
| ctl_oe | output | 1 | Output enable for FRAME#, IRDY#, C/BE# |
| ad_out | output | AW | Address driven in the address phase |
| ad_oe | output | 1 | AD output enable |
| ad_in | input | AW | Read data from the target |
| trdy_n | input | 1 | TRDY#, active low |
| stop_n | input | 1 | STOP#, active low |
| fifo_free | input | FREE_W | Free entries in the receive FIFO |
| fifo_wr | output | 1 | Write strobe to the receive FIFO |
| fifo_wdata | output | AW | Data written to the receive FIFO |
| rem_bytes | output | CNT_W | Bytes still to read |
| busy | output | 1 | Engine not in IDLE |

## Verification
The cycle-by-cycle properties are checked on every clock:
- the address phase always carries the read command and is followed by a driven-off turnaround;
- each FIFO write lines up with a TRDY#/IRDY# handshake and a free FIFO entry, and takes exactly four bytes off the count;
- a lost grant, a disable, a STOP# or a priority write seen in mid-burst makes FRAME# rise next cycle;
- FRAME# never rises without IRDY#.

Some behaviours depend on a whole transaction and only the bench scenarios can show them. These are the exact number of dwords taken under each termination cause, the ignored starts, the abandoned request and the single-dword case. The scenarios compare those totals with hand-computed values.

// File: rtl/pcird_pkg.sv
package pcird_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ADDR,
        ST_TURN,
        ST_DATA
    } rd_state_t;

    localparam logic [3:0] CMD_MEM_READ = 4'b0110;
    localparam logic [3:0] BE_ALL_ON    = 4'b0000;
endpackage

// File: rtl/pcird_ctr.sv
// Byte countdown and latched start address for one burst.
module pcird_ctr #(
    parameter int CNT_W = 12,
    parameter int AW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_bytes,
    input  logic [AW-1:0]    load_addr,
    input  logic             dec,
    output logic [CNT_W-1:0] rem_bytes,
    output logic [AW-1:0]    base_addr
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(4);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_bytes <= '0;
            base_addr <= '0;
        end else if (load) begin
            rem_bytes <= {load_bytes[CNT_W-1:2], 2'b00};
            base_addr <= {load_addr[AW-1:2], 2'b00};
        end else if (dec) begin
            rem_bytes <= rem_bytes - STEP;
        end
    end
endmodule

// File: rtl/pcird_term.sv
// Decides whether the next data phase must be the final one.
module pcird_term #(
    parameter int CNT_W  = 12,
    parameter int FREE_W = 6
) (
    input  logic [CNT_W-3:0]  rem_dw,
    input  logic [FREE_W-1:0] fifo_free,
    input  logic              xfer,
    input  logic              gnt_n,
    input  logic              master_en,
    input  logic              prio_mode,
    input  logic              prio_pend,
    input  logic              stop_n,
    output logic              end_now
);
    localparam int DW_W = CNT_W - 2;

    logic [DW_W:0]   dw_after;
    logic [FREE_W:0] fr_after;
    logic            budget_last;

    always_comb begin
        dw_after    = {1'b0, rem_dw} - {{DW_W{1'b0}}, xfer};
        fr_after    = {1'b0, fifo_free} - {{FREE_W{1'b0}}, xfer};
        budget_last = (dw_after <= (DW_W+1)'(1)) || (fr_after <= (FREE_W+1)'(1));
        end_now     = budget_last || gnt_n || !master_en || !stop_n
                      || (prio_mode && prio_pend);
    end
endmodule

// File: rtl/pci_rd_burst_master.sv
module pci_rd_burst_master
    import pcird_pkg::*;
#(
    parameter int AW     = 32,
    parameter int CNT_W  = 12,
    parameter int FREE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     start_addr,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic              master_en,
    input  logic              prio_mode,
    input  logic              prio_pend,
    output logic              req_n,
    input  logic              gnt_n,
    output logic              frame_n,
    output logic              irdy_n,
    output logic [3:0]        cbe_n,
    output logic              ctl_oe,
    output logic [AW-1:0]     ad_out,
    output logic              ad_oe,
    input  logic [AW-1:0]     ad_in,
    input  logic              trdy_n,
    input  logic              stop_n,
    input  logic [FREE_W-1:0] fifo_free,
    output logic              fifo_wr,
    output logic [AW-1:0]     fifo_wdata,
    output logic [CNT_W-1:0]  rem_bytes,
    output logic              busy
);
    rd_state_t     st_q, st_nx;
    logic          last_q, last_nx;
    logic          load, xfer, end_now, start_ok, prio_block;
    logic [AW-1:0] base_addr;

    assign start_ok   = (byte_cnt[CNT_W-1:2] != '0);
    assign prio_block = prio_mode && prio_pend;
    assign xfer       = (st_q == ST_DATA) && !trdy_n;

    pcird_ctr #(.CNT_W(CNT_W), .AW(AW)) ctr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_bytes (byte_cnt),
        .load_addr  (start_addr),
        .dec        (xfer),
        .rem_bytes  (rem_bytes),
        .base_addr  (base_addr)
    );

    pcird_term #(.CNT_W(CNT_W), .FREE_W(FREE_W)) term_i (
        .rem_dw    (rem_bytes[CNT_W-1:2]),
        .fifo_free (fifo_free),
        .xfer      (xfer),
        .gnt_n     (gnt_n),
        .master_en (master_en),
        .prio_mode (prio_mode),
        .prio_pend (prio_pend),
        .stop_n    (stop_n),
        .end_now   (end_now)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            last_q <= 1'b0;
        end else begin
            st_q   <= st_nx;
            last_q <= last_nx;
        end
    end

    // transitions
    always_comb begin
        st_nx   = st_q;
        last_nx = last_q;
        load    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start && start_ok) begin
                    st_nx   = ST_REQ;
                    last_nx = 1'b0;
                    load    = 1'b1;
                end
            end
            ST_REQ: begin
                if (!master_en) begin
                    st_nx = ST_IDLE;
                end else if (!gnt_n && !prio_block && (fifo_free != '0)) begin
                    st_nx   = ST_ADDR;
                    last_nx = 1'b0;
                end
            end
            ST_ADDR: begin
                st_nx   = ST_TURN;
                last_nx = end_now;
            end
            ST_TURN: begin
                st_nx   = ST_DATA;
                last_nx = last_q || end_now;
            end
            ST_DATA: begin
                if (last_q && (xfer || !stop_n)) begin
                    st_nx = ST_IDLE;
                end else begin
                    last_nx = last_q || end_now;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_n      = (st_q == ST_IDLE);
        busy       = (st_q != ST_IDLE);
        ad_oe      = (st_q == ST_ADDR);
        ad_out     = base_addr;
        ctl_oe     = (st_q == ST_ADDR) || (st_q == ST_TURN) || (st_q == ST_DATA);
        irdy_n     = !((st_q == ST_TURN) || (st_q == ST_DATA));
        frame_n    = !((st_q == ST_ADDR) ||
                       (((st_q == ST_TURN) || (st_q == ST_DATA)) && !last_q));
        cbe_n      = (st_q == ST_ADDR) ? CMD_MEM_READ : BE_ALL_ON;
        fifo_wr    = xfer;
        fifo_wdata = ad_in;
    end
endmodule

// File: rtl/pcird_chk.sv
module pcird_chk #(
    parameter int CNT_W  = 12,
    parameter int FREE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_n,
    input logic              irdy_n,
    input logic              ctl_oe,
    input logic              ad_oe,
    input logic [3:0]        cbe_n,
    input logic              gnt_n,
    input logic              master_en,
    input logic              prio_mode,
    input logic              prio_pend,
    input logic              trdy_n,
    input logic              stop_n,
    input logic [FREE_W-1:0] fifo_free,
    input logic              fifo_wr,
    input logic [CNT_W-1:0]  rem_bytes
);
    a_r3_addr_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (!frame_n && irdy_n && cbe_n == 4'b0110));

    a_r4_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |=> (!ad_oe && !irdy_n && !fifo_wr));

    a_r5_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> (!irdy_n && !trdy_n && !ad_oe));

    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |=> (rem_bytes == $past(rem_bytes) - CNT_W'(4)));

    a_r6_last_dword: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && !irdy_n && fifo_wr && rem_bytes == CNT_W'(8)) |=> frame_n);

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> (fifo_free != '0));

    a_r8_grant_lost: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && !irdy_n && gnt_n) |=> frame_n);

    a_r9_prio_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && !irdy_n && prio_mode && prio_pend) |=> frame_n);

    a_r10_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && !irdy_n && !master_en) |=> frame_n);

    a_r11_target_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && !irdy_n && !stop_n) |=> frame_n);

    a_r12_frame_with_irdy: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_oe && frame_n) |-> !irdy_n);

    a_r12_release: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && frame_n) |=> (frame_n && irdy_n && !ctl_oe));
endmodule

bind pci_rd_burst_master pcird_chk #(.CNT_W(CNT_W), .FREE_W(FREE_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .ctl_oe    (ctl_oe),
    .ad_oe     (ad_oe),
    .cbe_n     (cbe_n),
    .gnt_n     (gnt_n),
    .master_en (master_en),
    .prio_mode (prio_mode),
    .prio_pend (prio_pend),
    .trdy_n    (trdy_n),
    .stop_n    (stop_n),
    .fifo_free (fifo_free),
    .fifo_wr   (fifo_wr),
    .rem_bytes (rem_bytes)
);

// File: tb/pci_rd_burst_master_tb_top.sv
module pci_rd_burst_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int CNT_W = 12;
    localparam int FREE_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [AW-1:0]     start_addr = '0;
    logic [CNT_W-1:0]  byte_cnt = '0;
    logic              master_en = 1'b1;
    logic              prio_mode = 1'b0;
    logic              prio_pend = 1'b0;
    logic              gnt_n = 1'b1;
    logic [AW-1:0]     ad_in = '0;
    logic              trdy_n = 1'b1;
    logic              stop_n = 1'b1;
    logic [FREE_W-1:0] fifo_free = '0;
    logic              req_n, frame_n, irdy_n, ctl_oe, ad_oe, fifo_wr, busy;
    logic [3:0]        cbe_n;
    logic [AW-1:0]     ad_out, fifo_wdata;
    logic [CNT_W-1:0]  rem_bytes;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    dut_words = 0;
    bit    finished = 0;
    string cur_tag = "R1";

    // behavioural reference: phase 0 idle,1 request,2 address,3 turnaround,4 data
    int          m_phase = 0;
    bit          m_final = 0;
    int          m_left = 0;
    logic [31:0] m_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_rd_burst_master #(.AW(AW), .CNT_W(CNT_W), .FREE_W(FREE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .byte_cnt(byte_cnt), .master_en(master_en), .prio_mode(prio_mode),
        .prio_pend(prio_pend), .req_n(req_n), .gnt_n(gnt_n), .frame_n(frame_n),
        .irdy_n(irdy_n), .cbe_n(cbe_n), .ctl_oe(ctl_oe), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .trdy_n(trdy_n), .stop_n(stop_n),
        .fifo_free(fifo_free), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .rem_bytes(rem_bytes), .busy(busy)
    );

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL [%s] %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit must_end(input int x);
        int dw = m_left / 4;
        return gnt_n || !master_en || !stop_n || (prio_mode && prio_pend)
               || ((dw - x) <= 1) || ((int'(fifo_free) - x) <= 1);
    endfunction

    always @(posedge clk) begin
        int x;
        if (!rst_n) begin
            m_phase = 0; m_final = 0; m_left = 0; m_addr = '0;
        end else begin
            x = (m_phase == 4 && !trdy_n) ? 1 : 0;
            case (m_phase)
                0: if (start && byte_cnt >= 4) begin
                       m_phase = 1; m_final = 0;
                       m_left = int'(byte_cnt) / 4 * 4;
                       m_addr = start_addr & 32'hFFFF_FFFC;
                   end
                1: if (!master_en) m_phase = 0;
                   else if (!gnt_n && !(prio_mode && prio_pend) && fifo_free != 0) begin
                       m_phase = 2; m_final = 0;
                   end
                2: begin m_final = must_end(0); m_phase = 3; end
                3: begin m_final = m_final | must_end(0); m_phase = 4; end
                default: begin
                    if (m_final && (x == 1 || !stop_n)) m_phase = 0;
                    else m_final = m_final | must_end(x);
                end
            endcase
            if (x == 1) begin
                m_left -= 4;
                fifo_free <= fifo_free - 1'b1;
            end
        end
    end

    always @(negedge clk) begin
        #1;
        if (rst_n && !finished) begin
            bit e_wr;
            e_wr = (m_phase == 4) && !trdy_n;
            if (fifo_wr) dut_words++;
            check("R3", "req_n", req_n, m_phase == 0);
            check(cur_tag, "frame_n", frame_n, !(m_phase == 2 || (m_phase >= 3 && !m_final)));
            check("R12", "irdy_n", irdy_n, m_phase < 3);
            check("R12", "ctl_oe", ctl_oe, m_phase >= 2);
            check("R4", "ad_oe", ad_oe, m_phase == 2);
            if (m_phase == 2) check("R3", "ad_out", ad_out, m_addr);
            if (m_phase >= 2) check("R3", "cbe_n", cbe_n, (m_phase == 2) ? 4'b0110 : 4'b0000);
            check("R5", "fifo_wr", fifo_wr, e_wr);
            if (e_wr) check("R5", "fifo_wdata", fifo_wdata, ad_in);
            check("R5", "rem_bytes", rem_bytes, m_left);
            check("R2", "busy", busy, m_phase != 0);
        end
    end

    task automatic run(input string tag, input int bytes, input logic [31:0] addr,
                       input int free0, input logic [31:0] tmask, input int gnt_drop,
                       input int prio_at, input bit pmode, input int men_drop,
                       input int stop_at, input int restart_at,
                       input int exp_words, input int exp_rem);
        @(negedge clk);
        cur_tag = tag;
        fifo_free = FREE_W'(free0);
        dut_words = 0;
        for (int c = 0; c < 40; c++) begin
            start      = (c == 0) || (c == restart_at);
            byte_cnt   = (c == 0) ? CNT_W'(bytes) : CNT_W'(40);
            start_addr = addr;
            gnt_n      = !(c >= 1 && c < gnt_drop);
            prio_mode  = pmode;
            prio_pend  = (prio_at >= 0) && (c >= prio_at);
            master_en  = !((men_drop >= 0) && (c >= men_drop));
            stop_n     = !((stop_at >= 0) && (c >= stop_at));
            trdy_n     = !tmask[c % 32] || (c >= 32);
            ad_in      = 32'hC0DE_0000 + c;
            @(negedge clk);
        end
        start = 0; gnt_n = 1; stop_n = 1; trdy_n = 1; master_en = 1; prio_pend = 0;
        repeat (2) @(negedge clk);
        #2;
        check(tag, "dwords taken", dut_words, exp_words);
        check(tag, "bytes left", rem_bytes, exp_rem);
        check(tag, "back to idle", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1", "req_n in reset", req_n, 1);
        check("R1", "frame_n in reset", frame_n, 1);
        check("R1", "irdy_n in reset", irdy_n, 1);
        check("R1", "oe in reset", {ctl_oe, ad_oe}, 0);
        check("R1", "fifo_wr/busy in reset", {fifo_wr, busy}, 0);
        rst_n = 1;
        // R6 + R2: four dwords by count, restart while busy ignored
        run("R6", 16, 32'h1000_0003, 16, 32'hFFFF_FFFF, 99, -1, 0, -1, -1, 5, 4, 0);
        // R5: wait states between transfers
        run("R5", 12, 32'h2000_0010, 16, 32'h5555_5550, 99, -1, 0, -1, -1, -1, 3, 0);
        // R7: FIFO room for three
        run("R7", 64, 32'h3000_0000, 3, 32'hFFFF_FFFF, 99, -1, 0, -1, -1, -1, 3, 52);
        // R8: grant removed in cycle 6
        run("R8", 64, 32'h4000_0000, 32, 32'hFFFF_FFFF, 6, -1, 0, -1, -1, -1, 4, 48);
        // R9: priority write with mode on, then with mode off
        run("R9", 64, 32'h5000_0000, 32, 32'hFFFF_FFFF, 99, 5, 1, -1, -1, -1, 3, 52);
        run("R9", 16, 32'h5100_0000, 32, 32'hFFFF_FFFF, 99, 2, 0, -1, -1, -1, 4, 0);
        // R10: disable mid-burst, then disable in request
        run("R10", 64, 32'h6000_0000, 32, 32'hFFFF_FFFF, 99, -1, 0, 5, -1, -1, 3, 52);
        run("R10", 64, 32'h6100_0000, 32, 32'hFFFF_FFFF, 99, -1, 0, 1, -1, -1, 0, 64);
        // R11: stop with data, then stop without data
        run("R11", 64, 32'h7000_0000, 32, 32'h0000_0030, 99, -1, 0, -1, 5, -1, 2, 56);
        run("R11", 64, 32'h7100_0000, 32, 32'h0000_0030, 99, -1, 0, -1, 6, -1, 2, 56);
        // R2: count under one dword is ignored, counter untouched
        run("R2", 3, 32'h8000_0000, 32, 32'hFFFF_FFFF, 99, -1, 0, -1, -1, -1, 0, 56);
        // R6: single dword, FRAME# high already in turnaround
        run("R6", 4, 32'h9000_0004, 32, 32'hFFFF_FFFF, 99, -1, 0, -1, -1, -1, 1, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL [R12] watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule